// File: doc/BRIEF.md
# Framed Serial Byte Receiver

This block is the receive side of a serial link on an FPGA whose partner may
pull its transmit line low for one bit time when the partner opens its port. An
ordinary receiver sees that pulse as a start bit and produces a junk byte. Here
an oversampling 8N1 receiver turns the line into bytes. A message filter
follows it and passes on only the bytes that belong to a properly opened
message.

The filter waits for one of two opening symbols. It discards every byte that
arrives while it waits and counts those bytes. Once a message opens, it forwards
a fixed number of payload bytes. It marks the first of them with a start strobe
and the last with an end strobe, then goes back to waiting. A bad stop bit
raises a one-cycle error strobe and closes any open message.

Top module: `msg_uart_rx`

## Requirements
- R1: A falling edge on the line, after the two-flop synchronizer, starts a frame only if the line is still low at the 8th baud tick. A low glitch shorter than that produces no byte, no error and no count change.
- R2: Each frame is 8N1. The 8 data bits are sampled every 16 baud ticks after the start-bit centre, least significant bit first. All 256 data values are received intact.
- R3: After reset, no frame is decoded until the line has been high for at least 10 bit periods (160 ticks) in a row. A low pulse during that window restarts the wait.
- R4: If the stop-bit sample is low, the byte is discarded and `frameErr` is high for exactly one cycle. The byte is neither forwarded nor counted as dropped.
- R5: A framing error closes an open message. Bytes after it are dropped until a new opening symbol arrives.
- R6: While waiting, a byte of value 0x01 or 0x02 opens a message and is not forwarded.
- R7: An open message forwards exactly PAYLOAD_LEN bytes. `outSom` goes with the first, `outEom` goes with the last, and both occur only together with `outValid`. The block then waits for the next opening symbol.
- R8: The values 0x01 and 0x02 inside a payload are forwarded as ordinary data.
- R9: Every correctly framed byte received while waiting that is not 0x01 or 0x02 is dropped. Each one adds 1 to `dropCount`, which holds at its maximum value and never decreases.
- R10: A single low pulse of one bit period on an idle line decodes as 0xFF. It is dropped, counted, and never reaches `outValid`.
- R11: Reset clears all outputs to zero. `outValid` and `frameErr` are single-cycle strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rxLine | input | 1 | Asynchronous serial input, idle high |
| baudTick | input | 1 | Enable pulse at 16 times the bit rate |
| outData | output | 8 | Forwarded payload byte |
| outValid | output | 1 | outData valid for one cycle |
| outSom | output | 1 | First payload byte of a message |
| outEom | output | 1 | Last payload byte of a message |
| frameErr | output | 1 | Stop-bit sample was low (one cycle) |
| dropCount | output | DROP_W | Saturating count of discarded bytes |

## Verification
The hardest state to reach from the ports is a framing error in the middle of a message. A frame with a low stop bit is followed by line-low time, which the receiver must reject as a false start. The bench sends an opening symbol and two payload bytes, then a frame whose stop bit is held low for a full bit. It then checks that the next two bytes are counted as dropped rather than forwarded. Counter saturation is reached by sweeping every non-opening byte value through the waiting filter. A second sweep carries all 256 values as payload.

// File: rtl/msgrx_pkg.sv
package msgrx_pkg;

  typedef enum logic [2:0] {
    RX_ARM,
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rxState_t;

  typedef enum logic {
    F_HUNT,
    F_PAY
  } filtState_t;

  // control -> datapath
  typedef struct packed {
    logic clrTick;
    logic incTick;
    logic clrBit;
    logic shiftBit;
    logic frameErr;
    logic openMsg;
    logic fwdByte;
    logic dropByte;
  } ctrlStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic rxSync;
    logic tickMid;
    logic tickLast;
    logic bitLast;
    logic idleOk;
    logic isStartSym;
    logic payLast;
  } dpStatus_t;

endpackage

// File: rtl/msgrx_ctrl.sv
module msgrx_ctrl
  import msgrx_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        baudTick,
  input  dpStatus_t   stat,
  output ctrlStrobe_t strb
);

  rxState_t   rxState, rxNext;
  filtState_t filtState, filtNext;
  logic       byteDone;

  always_ff @(posedge clk) begin
    if (rst) begin
      rxState   <= RX_ARM;
      filtState <= F_HUNT;
    end else begin
      rxState   <= rxNext;
      filtState <= filtNext;
    end
  end

  // bit-level receiver sequencing
  always_comb begin
    rxNext        = rxState;
    byteDone      = 1'b0;
    strb.clrTick  = 1'b0;
    strb.incTick  = 1'b0;
    strb.clrBit   = 1'b0;
    strb.shiftBit = 1'b0;
    strb.frameErr = 1'b0;
    case (rxState)
      RX_ARM: begin
        if (stat.idleOk) rxNext = RX_IDLE;
      end
      RX_IDLE: begin
        if (!stat.rxSync) begin
          strb.clrTick = 1'b1;
          rxNext       = RX_START;
        end
      end
      RX_START: begin
        if (baudTick) begin
          if (stat.tickMid) begin
            strb.clrTick = 1'b1;
            if (!stat.rxSync) begin
              strb.clrBit = 1'b1;
              rxNext      = RX_DATA;
            end else begin
              rxNext = RX_IDLE;
            end
          end else begin
            strb.incTick = 1'b1;
          end
        end
      end
      RX_DATA: begin
        if (baudTick) begin
          if (stat.tickLast) begin
            strb.clrTick  = 1'b1;
            strb.shiftBit = 1'b1;
            if (stat.bitLast) rxNext = RX_STOP;
          end else begin
            strb.incTick = 1'b1;
          end
        end
      end
      RX_STOP: begin
        if (baudTick) begin
          if (stat.tickLast) begin
            strb.clrTick = 1'b1;
            rxNext       = RX_IDLE;
            if (stat.rxSync) byteDone = 1'b1;
            else             strb.frameErr = 1'b1;
          end else begin
            strb.incTick = 1'b1;
          end
        end
      end
      default: rxNext = RX_ARM;
    endcase
  end

  // message filter
  always_comb begin
    filtNext      = filtState;
    strb.openMsg  = 1'b0;
    strb.fwdByte  = 1'b0;
    strb.dropByte = 1'b0;
    if (strb.frameErr) begin
      filtNext = F_HUNT;
    end else if (byteDone) begin
      case (filtState)
        F_HUNT: begin
          if (stat.isStartSym) begin
            strb.openMsg = 1'b1;
            filtNext     = F_PAY;
          end else begin
            strb.dropByte = 1'b1;
          end
        end
        F_PAY: begin
          strb.fwdByte = 1'b1;
          if (stat.payLast) filtNext = F_HUNT;
        end
        default: filtNext = F_HUNT;
      endcase
    end
  end

  // R3: a frame may only begin once the idle window has been seen
  p_arm_gate_r3: assert property (@(posedge clk) disable iff (rst)
    (rxState == RX_ARM) |=> (rxState == RX_ARM || rxState == RX_IDLE));

endmodule

// File: rtl/msgrx_dp.sv
module msgrx_dp
  import msgrx_pkg::*;
#(
  parameter int OVERSAMPLE  = 16,
  parameter int IDLE_BITS   = 10,
  parameter int PAYLOAD_LEN = 4,
  parameter int DROP_W      = 8,
  parameter logic [7:0] START_A = 8'h01,
  parameter logic [7:0] START_B = 8'h02
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rxLine,
  input  logic              baudTick,
  input  ctrlStrobe_t       strb,
  output dpStatus_t         stat,
  output logic [7:0]        outData,
  output logic              outValid,
  output logic              outSom,
  output logic              outEom,
  output logic              frameErr,
  output logic [DROP_W-1:0] dropCount
);

  localparam int TICK_W     = $clog2(OVERSAMPLE);
  localparam int IDLE_TICKS = IDLE_BITS * OVERSAMPLE;
  localparam int IDLE_W     = $clog2(IDLE_TICKS + 1);
  localparam int PAY_W      = $clog2(PAYLOAD_LEN + 1);
  localparam logic [DROP_W-1:0] DROP_MAX = {DROP_W{1'b1}};

  logic              rxMeta, rxSync;
  logic [TICK_W-1:0] tickCnt;
  logic [2:0]        bitCnt;
  logic [7:0]        shiftReg;
  logic [IDLE_W-1:0] idleCnt;
  logic [PAY_W-1:0]  payCnt;

  // two-flop synchronizer, idle high
  always_ff @(posedge clk) begin
    if (rst) begin
      rxMeta <= 1'b1;
      rxSync <= 1'b1;
    end else begin
      rxMeta <= rxLine;
      rxSync <= rxMeta;
    end
  end

  // oversample tick and bit counters, data shifter
  always_ff @(posedge clk) begin
    if (rst) begin
      tickCnt  <= '0;
      bitCnt   <= '0;
      shiftReg <= '0;
    end else begin
      if (strb.clrTick)      tickCnt <= '0;
      else if (strb.incTick) tickCnt <= tickCnt + 1'b1;
      if (strb.clrBit)        bitCnt <= '0;
      else if (strb.shiftBit) bitCnt <= bitCnt + 1'b1;
      if (strb.shiftBit) shiftReg <= {rxSync, shiftReg[7:1]};
    end
  end

  // continuous-high window after reset
  always_ff @(posedge clk) begin
    if (rst) begin
      idleCnt <= '0;
    end else if (!rxSync) begin
      idleCnt <= '0;
    end else if (baudTick && idleCnt != IDLE_W'(IDLE_TICKS)) begin
      idleCnt <= idleCnt + 1'b1;
    end
  end

  // payload position
  always_ff @(posedge clk) begin
    if (rst) begin
      payCnt <= '0;
    end else if (strb.openMsg) begin
      payCnt <= '0;
    end else if (strb.fwdByte) begin
      payCnt <= payCnt + 1'b1;
    end
  end

  // registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      outData   <= '0;
      outValid  <= 1'b0;
      outSom    <= 1'b0;
      outEom    <= 1'b0;
      frameErr  <= 1'b0;
      dropCount <= '0;
    end else begin
      outValid <= strb.fwdByte;
      outSom   <= strb.fwdByte && (payCnt == '0);
      outEom   <= strb.fwdByte && stat.payLast;
      frameErr <= strb.frameErr;
      if (strb.fwdByte) outData <= shiftReg;
      if (strb.dropByte && dropCount != DROP_MAX) dropCount <= dropCount + 1'b1;
    end
  end

  always_comb begin
    stat.rxSync     = rxSync;
    stat.tickMid    = (tickCnt == TICK_W'(OVERSAMPLE / 2 - 1));
    stat.tickLast   = (tickCnt == TICK_W'(OVERSAMPLE - 1));
    stat.bitLast    = (bitCnt == 3'd7);
    stat.idleOk     = (idleCnt == IDLE_W'(IDLE_TICKS));
    stat.isStartSym = (shiftReg == START_A) || (shiftReg == START_B);
    stat.payLast    = (payCnt == PAY_W'(PAYLOAD_LEN - 1));
  end

  // R7: markers only accompany a forwarded byte
  p_som_valid_r7: assert property (@(posedge clk) disable iff (rst)
    outSom |-> outValid);
  p_eom_valid_r7: assert property (@(posedge clk) disable iff (rst)
    outEom |-> outValid);
  // R4: an errored frame is never forwarded, error is one cycle
  p_err_excl_r4: assert property (@(posedge clk) disable iff (rst)
    frameErr |-> !outValid);
  p_err_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    frameErr |=> !frameErr);
  // R9: drop counter never decreases
  p_drop_mono_r9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> dropCount >= $past(dropCount));
  // R11: valid is a single-cycle strobe
  p_valid_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    outValid |=> !outValid);

endmodule

// File: rtl/msg_uart_rx.sv
module msg_uart_rx
  import msgrx_pkg::*;
#(
  parameter int OVERSAMPLE  = 16,
  parameter int IDLE_BITS   = 10,
  parameter int PAYLOAD_LEN = 4,
  parameter int DROP_W      = 8,
  parameter logic [7:0] START_A = 8'h01,
  parameter logic [7:0] START_B = 8'h02
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rxLine,
  input  logic              baudTick,
  output logic [7:0]        outData,
  output logic              outValid,
  output logic              outSom,
  output logic              outEom,
  output logic              frameErr,
  output logic [DROP_W-1:0] dropCount
);

  ctrlStrobe_t strb;
  dpStatus_t   stat;

  msgrx_ctrl i_ctrl (
    .clk      (clk),
    .rst      (rst),
    .baudTick (baudTick),
    .stat     (stat),
    .strb     (strb)
  );

  msgrx_dp #(
    .OVERSAMPLE  (OVERSAMPLE),
    .IDLE_BITS   (IDLE_BITS),
    .PAYLOAD_LEN (PAYLOAD_LEN),
    .DROP_W      (DROP_W),
    .START_A     (START_A),
    .START_B     (START_B)
  ) i_dp (
    .clk       (clk),
    .rst       (rst),
    .rxLine    (rxLine),
    .baudTick  (baudTick),
    .strb      (strb),
    .stat      (stat),
    .outData   (outData),
    .outValid  (outValid),
    .outSom    (outSom),
    .outEom    (outEom),
    .frameErr  (frameErr),
    .dropCount (dropCount)
  );

endmodule

// File: tb/test_msg_uart_rx.sv
module test_msg_uart_rx;

  localparam int PL = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rxLine = 1'b1;
  logic       baudTick = 1'b0;
  logic [7:0] outData;
  logic       outValid, outSom, outEom, frameErr;
  logic [7:0] dropCount;

  int nChk = 0, nBad = 0;
  int tickTotal = 0;
  int recN = 0, errN = 0;
  logic [7:0] recData [0:1023];
  logic       recSom  [0:1023];
  logic       recEom  [0:1023];
  bit done = 0;
  int expDrop = 0;

  msg_uart_rx #(.PAYLOAD_LEN(PL), .DROP_W(8)) i_msg_uart_rx (
    .clk(clk), .rst(rst), .rxLine(rxLine), .baudTick(baudTick),
    .outData(outData), .outValid(outValid), .outSom(outSom),
    .outEom(outEom), .frameErr(frameErr), .dropCount(dropCount)
  );

  always #5 clk = ~clk;

  // baud tick on 7 of every 8 cycles
  initial begin
    int phase = 0;
    forever begin
      @(negedge clk);
      baudTick = (phase != 7);
      phase = (phase + 1) % 8;
    end
  end

  always @(posedge clk) if (baudTick) tickTotal <= tickTotal + 1;

  always @(negedge clk) begin
    if (!rst) begin
      if (outValid) begin
        recData[recN % 1024] = outData;
        recSom[recN % 1024]  = outSom;
        recEom[recN % 1024]  = outEom;
        recN++;
      end
      if (frameErr) errN++;
    end
  end

  task automatic chkEq(input string tag, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic waitTicks(input int n);
    int target = tickTotal + n;
    while (tickTotal < target) @(negedge clk);
  endtask

  task automatic sendByte(input logic [7:0] d, input logic stopBit);
    rxLine = 1'b0; waitTicks(16);
    for (int i = 0; i < 8; i++) begin
      rxLine = d[i]; waitTicks(16);
    end
    rxLine = stopBit; waitTicks(16);
    rxLine = 1'b1; waitTicks(16);
  endtask

  task automatic sendMsg(input logic [7:0] opener, input int base, input logic [7:0] p [PL]);
    int r0 = recN;
    sendByte(opener, 1'b1);
    for (int k = 0; k < PL; k++) sendByte(p[k], 1'b1);
    chkEq("R7 forwarded count", recN - r0, PL);
    for (int k = 0; k < PL; k++) begin
      chkEq("R2 payload data", int'(recData[(r0 + k) % 1024]), int'(p[k]));
      chkEq("R7 som flag", int'(recSom[(r0 + k) % 1024]), (k == 0) ? 1 : 0);
      chkEq("R7 eom flag", int'(recEom[(r0 + k) % 1024]), (k == PL - 1) ? 1 : 0);
    end
    chkEq("R6 opener not counted", int'(dropCount), expDrop);
    if (base < 0) $display("unused");
  endtask

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      nChk++; nBad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      finishRun();
    end
  end

  initial begin
    logic [7:0] p [PL];
    int r0, e0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chkEq("R11 reset outValid", int'(outValid), 0);
    chkEq("R11 reset frameErr", int'(frameErr), 0);
    chkEq("R11 reset dropCount", int'(dropCount), 0);
    chkEq("R11 reset outData", int'(outData), 0);

    // R3: a full frame before the idle window is ignored
    waitTicks(40);
    sendByte(8'h41, 1'b1);
    chkEq("R3 no decode before idle window", int'(dropCount), 0);
    chkEq("R3 no error before idle window", errN, 0);
    waitTicks(12 * 16);

    // R1: short glitch is not a start
    rxLine = 1'b0; waitTicks(4); rxLine = 1'b1; waitTicks(48);
    chkEq("R1 glitch no drop", int'(dropCount), 0);
    chkEq("R1 glitch no error", errN, 0);

    // R10: single spurious bit-long low pulse
    rxLine = 1'b0; waitTicks(16); rxLine = 1'b1; waitTicks(12 * 16);
    expDrop = 1;
    chkEq("R10 spurious pulse dropped", int'(dropCount), expDrop);
    chkEq("R10 spurious pulse not forwarded", recN, 0);

    // R6/R7/R8 messages, both openers, openers inside payload
    for (int m = 0; m < 6; m++) begin
      for (int k = 0; k < PL; k++) p[k] = 8'((m * 37 + k * 11 + 5) & 255);
      if (m == 0) begin p[0] = 8'h01; p[2] = 8'h02; end // R8
      if (m == 3) begin p[1] = 8'h02; p[3] = 8'h01; end // R8
      sendMsg((m % 2) ? 8'h02 : 8'h01, m, p);
    end

    // R4: bad stop while hunting
    r0 = recN; e0 = errN;
    sendByte(8'h5A, 1'b0);
    chkEq("R4 error strobe counted", errN - e0, 1);
    chkEq("R4 errored byte not dropped-counted", int'(dropCount), expDrop);
    chkEq("R4 errored byte not forwarded", recN - r0, 0);

    // R5: bad stop mid-message closes it
    r0 = recN; e0 = errN;
    sendByte(8'h01, 1'b1);
    sendByte(8'h10, 1'b1);
    sendByte(8'h20, 1'b1);
    sendByte(8'h77, 1'b0);
    sendByte(8'h33, 1'b1);
    sendByte(8'h44, 1'b1);
    expDrop += 2;
    chkEq("R5 two bytes forwarded before error", recN - r0, 2);
    chkEq("R5 first byte som", int'(recSom[r0 % 1024]), 1);
    chkEq("R5 no eom issued", int'(recEom[(r0 + 1) % 1024]), 0);
    chkEq("R5 error strobe", errN - e0, 1);
    chkEq("R5 later bytes dropped", int'(dropCount), expDrop);

    // R9 sweep of every non-opener value in hunt, through saturation
    r0 = recN;
    for (int v = 0; v < 256; v++) begin
      if (v == 1 || v == 2) continue;
      sendByte(8'(v), 1'b1);
      expDrop = (expDrop < 255) ? expDrop + 1 : 255;
      chkEq("R9 drop count", int'(dropCount), expDrop);
    end
    chkEq("R9 nothing forwarded in sweep", recN - r0, 0);

    // R2 every data value as payload
    for (int m = 0; m < 256 / PL; m++) begin
      for (int k = 0; k < PL; k++) p[k] = 8'(m * PL + k);
      sendMsg(8'h02, m, p);
    end
    chkEq("R11 no spurious error strobes", errN, 2);

    done = 1;
    finishRun();
  end

endmodule